// File: doc/BRIEF.md
# Disparity-Bounded 64b/67b Line Encoder

This block turns a stream of 64-bit payload words, each tagged with a 2-bit sync header, into 67-bit code words for a serial lane. It scrambles the payload with a self-synchronizing scrambler, so the line carries frequent transitions. It adds one extra overhead bit beyond the usual two-bit header, and that bit is what keeps the long-term balance of ones and zeros bounded.

For every word, the block counts the ones in the scrambled payload. It then asks whether sending the payload as it stands, or sending its bitwise complement, leaves the accumulated disparity closer to zero. When the complement is better, the complement is sent and the inversion flag is raised. The header is always one of the two balanced patterns, so it is never complemented and takes no part in the tally.

The block sits between a word source and a serializer. Both sides use valid/ready handshakes, and the block has a single registered output stage.

Top module: `enc67_encoder`

## Requirements
- R1: The code word is packed as `out_word[66:65]` = header, `out_word[64]` = inversion flag, and `out_word[63:0]` = transmitted payload (the scrambled payload, complemented when the flag is 1).
- R2: The header field is passed through unchanged and is never complemented. For legal input it is always `01` or `10`.
- R3: Scrambling is done LSB first. Scrambled bit s = d XOR (scrambled bit 39 positions earlier) XOR (scrambled bit 58 positions earlier). The history is made of the scrambled bits before any complementing, carries across words, and is all zero after reset.
- R4: Let d be the payload disparity (2 × ones − 64) and RD the running disparity. The flag is 1 exactly when |RD + d − 1| > |RD − d + 1|. Otherwise the payload is sent as is with the flag at 0.
- R5: RD resets to 0. For each word that leaves the block, RD adds (+1 if the flag is 1, −1 if it is 0) plus the disparity of the transmitted payload. |RD| never exceeds 96.
- R6: A word whose decision is made while RD is exactly 0 is sent with the flag at 0.
- R7: `in_ready` is 1 when the output stage is empty or `out_ready` is 1. A word accepted on one edge shows `out_valid` = 1 after that edge. The stage empties when its word is taken and nothing new is accepted.
- R8: While `out_valid` = 1 and `out_ready` = 0, the output word and `out_valid` hold their values.
- R9: Neither the scrambler history nor RD moves unless a word is accepted or leaves the block, so the code word sequence does not depend on backpressure or gaps in the input.
- R10: During and right after reset, `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Block can take a word this cycle |
| in_hdr | input | 2 | Sync header, `01` or `10` |
| in_payload | input | 64 | Unscrambled payload |
| out_valid | output | 1 | Output stage holds a code word |
| out_ready | input | 1 | Sink takes the code word this cycle |
| out_word | output | 67 | Header, inversion flag, payload |

## Verification
The header-pattern assertion assumes that the source only ever presents `01` or `10` in the header. The bench picks the header between these two values and nothing else. The stall-hold check assumes that the sink is the only thing that releases the output stage. The bench also keeps a word stable while it waits on `in_ready`, so it does not retract an offered word. Some payloads are built by inverting the scrambler taps against the model history, so that the scrambled words reach chosen extreme disparities. This drives RD toward its bound without feeding anything that a real source could not send.

// File: rtl/enc67_pkg.sv
`timescale 1ns/1ps
package enc67_pkg;

    localparam int PAY_W    = 64;
    localparam int HDR_W    = 2;
    localparam int WORD_W   = PAY_W + HDR_W + 1;
    localparam int SCR_LEN  = 58;
    localparam int SCR_TAP  = 39;
    localparam int RD_LIMIT = 96;
    localparam int CNT_W    = $clog2(PAY_W) + 1;
    localparam int RD_W     = $clog2(RD_LIMIT + PAY_W + 2) + 1;

    typedef logic [PAY_W-1:0]          payload_t;
    typedef logic [SCR_LEN-1:0]        scr_state_t;
    typedef logic signed [RD_W-1:0]    rd_t;

    localparam scr_state_t SCR_SEED = '0;

    typedef struct packed {
        logic [HDR_W-1:0] hdr;
        logic             inv;
        payload_t         pay;
    } code_word_t;

    typedef struct packed {
        scr_state_t state;
        payload_t   data;
    } scr_result_t;

    // One 64-bit step of the x^58 + x^39 + 1 self-synchronizing scrambler.
    // ext[SCR_LEN-1] is the newest history bit; ext grows upward bit by bit.
    function automatic scr_result_t scramble_step(scr_state_t st, payload_t din);
        logic [SCR_LEN+PAY_W-1:0] ext;
        scr_result_t res;
        ext = '0;
        ext[SCR_LEN-1:0] = st;
        for (int i = 0; i < PAY_W; i++) begin
            ext[SCR_LEN+i] = din[i] ^ ext[SCR_LEN-SCR_TAP+i] ^ ext[i];
        end
        res.data  = ext[SCR_LEN +: PAY_W];
        res.state = ext[PAY_W +: SCR_LEN];
        return res;
    endfunction

    function automatic rd_t rd_abs(rd_t v);
        return (v < 0) ? -v : v;
    endfunction

endpackage

// File: rtl/enc67_popcount.sv
`timescale 1ns/1ps
module enc67_popcount #(
    parameter int W = 64
) (
    input  logic [W-1:0]          bits,
    output logic [$clog2(W):0]    ones
);
    localparam int CW = $clog2(W) + 1;

    // Heap-ordered adder tree: leaves at W..2W-1, root at 1.
    logic [CW-1:0] node [1:2*W-1];

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_leaf
            assign node[W+gi] = CW'(bits[gi]);
        end
        for (gi = 1; gi < W; gi++) begin : g_sum
            assign node[gi] = node[2*gi] + node[2*gi+1];
        end
    endgenerate

    assign ones = node[1];

endmodule

// File: rtl/enc67_scrambler.sv
`timescale 1ns/1ps
module enc67_scrambler
    import enc67_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     advance,
    input  payload_t din,
    output payload_t dout
);
    scr_state_t  state_q;
    scr_result_t step;

    always_comb step = scramble_step(state_q, din);

    assign dout = step.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCR_SEED;
        end else if (advance) begin
            state_q <= step.state;
        end
    end

    // R9
    scr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(state_q));

endmodule

// File: rtl/enc67_inv_select.sv
`timescale 1ns/1ps
module enc67_inv_select
    import enc67_pkg::*;
(
    input  rd_t  rd_now,
    input  rd_t  pay_disp,
    output logic invert,
    output rd_t  word_disp
);
    localparam rd_t ONE = rd_t'(1);

    rd_t keep_rd;
    rd_t flip_rd;

    always_comb begin
        keep_rd   = rd_now + pay_disp - ONE;
        flip_rd   = rd_now - pay_disp + ONE;
        invert    = rd_abs(keep_rd) > rd_abs(flip_rd);
        word_disp = invert ? (ONE - pay_disp) : (pay_disp - ONE);
    end

endmodule

// File: rtl/enc67_encoder.sv
`timescale 1ns/1ps
module enc67_encoder
    import enc67_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HDR_W-1:0]  in_hdr,
    input  logic [PAY_W-1:0]  in_payload,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);
    code_word_t       out_q;
    logic             out_valid_q;
    rd_t              rd_q;
    rd_t              held_disp_q;

    logic             in_fire;
    logic             out_fire;
    rd_t              rd_eff;
    payload_t         scr_pay;
    logic [CNT_W-1:0] ones;
    rd_t              pay_disp;
    logic             invert;
    rd_t              word_disp;

    assign in_ready = !out_valid_q || out_ready;
    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid_q && out_ready;

    // Running disparity as seen by the word being accepted now: include the
    // held word when it leaves on this same edge.
    assign rd_eff = out_fire ? (rd_q + held_disp_q) : rd_q;

    enc67_scrambler u_scr (
        .clk     (clk),
        .rst     (rst),
        .advance (in_fire),
        .din     (in_payload),
        .dout    (scr_pay)
    );

    enc67_popcount #(.W(PAY_W)) u_cnt (
        .bits (scr_pay),
        .ones (ones)
    );

    assign pay_disp = rd_t'({ones, 1'b0}) - rd_t'(PAY_W);

    enc67_inv_select u_sel (
        .rd_now    (rd_eff),
        .pay_disp  (pay_disp),
        .invert    (invert),
        .word_disp (word_disp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_q       <= '0;
            held_disp_q <= '0;
            rd_q        <= '0;
        end else begin
            rd_q <= rd_eff;
            if (in_fire) begin
                out_valid_q <= 1'b1;
                out_q.hdr   <= in_hdr;
                out_q.inv   <= invert;
                out_q.pay   <= invert ? ~scr_pay : scr_pay;
                held_disp_q <= word_disp;
            end else if (out_fire) begin
                out_valid_q <= 1'b0;
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_word  = out_q;

    // R5
    rd_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rd_abs(rd_q) <= rd_t'(RD_LIMIT));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_q && !out_ready) |=> (out_valid_q && $stable(out_q)));

    // R2
    preamble_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_q |-> (out_q.hdr == 2'b01 || out_q.hdr == 2'b10));

    // R6
    zero_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (in_fire && rd_eff == '0) |=> !out_q.inv);

    // R7
    fill_chk: assert property (@(posedge clk) disable iff (rst)
        in_fire |=> out_valid_q);

endmodule

// File: tb/tb_enc67_encoder.sv
`timescale 1ns/1ps
module tb_enc67_encoder;
    import enc67_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [1:0]  in_hdr;
    logic [63:0] in_payload;
    logic        out_valid;
    logic        out_ready;
    logic [66:0] out_word;

    always #2.5 clk = ~clk;

    enc67_encoder dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_hdr     (in_hdr),
        .in_payload (in_payload),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_word   (out_word)
    );

    typedef struct packed {
        logic [66:0] w;
        logic        rdz;
    } exp_t;

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    exp_t        q[$];
    logic [57:0] m_hist;      // m_hist[0] = newest scrambled bit
    int          m_rd;
    int          obs_rd;
    bit          exp_ov;
    bit          prev_stall;
    logic [66:0] prev_word;
    bit          last_in_fire;

    task automatic chk(input bit ok, input string what,
                       input logic [66:0] act, input logic [66:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic int pop64(logic [63:0] v);
        int n = 0;
        for (int i = 0; i < 64; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference: serial scrambler, then the candidate comparison.
    task automatic model_accept(input logic [1:0] h, input logic [63:0] d);
        logic [63:0] s;
        int dd, keep, flip;
        bit inv;
        exp_t e;
        for (int i = 0; i < 64; i++) begin
            s[i]   = d[i] ^ m_hist[38] ^ m_hist[57];
            m_hist = {m_hist[56:0], s[i]};
        end
        dd    = 2 * pop64(s) - 64;
        keep  = m_rd + dd - 1;
        flip  = m_rd - dd + 1;
        inv   = iabs(keep) > iabs(flip);
        e.rdz = (m_rd == 0);
        e.w   = {h, inv, (inv ? ~s : s)};
        m_rd  = inv ? flip : keep;
        q.push_back(e);
    endtask

    // Input payload whose scrambled image equals the target.
    function automatic logic [63:0] craft(logic [63:0] target);
        logic [57:0] h = m_hist;
        logic [63:0] d;
        for (int i = 0; i < 64; i++) begin
            d[i] = target[i] ^ h[38] ^ h[57];
            h    = {h[56:0], target[i]};
        end
        return d;
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [63:0] gen(int mode);
        case (mode)
            0: return rnd64();
            1: return 64'h0;
            2: return {64{1'b1}};
            3: return craft({64{1'b1}});
            4: return craft(($urandom % 2) ? (rnd64() | rnd64() | rnd64())
                                           : (rnd64() & rnd64() & rnd64()));
            default: return craft(($urandom % 2) ? 64'h0000_0000_FFFF_FFFF
                                                 : {{63{1'b0}}, 1'b1});
        endcase
    endfunction

    task automatic settle_and_check();
        bit in_f, out_f;
        exp_t e;
        int wd;
        #1;
        chk(out_valid == exp_ov, "R7 out_valid", {66'b0, out_valid}, {66'b0, exp_ov});
        chk(in_ready == (!out_valid || out_ready), "R7 in_ready",
            {66'b0, in_ready}, {66'b0, (!out_valid || out_ready)});
        if (prev_stall) chk(out_word == prev_word, "R8 held word", out_word, prev_word);
        in_f  = in_valid && in_ready;
        out_f = out_valid && out_ready;
        if (out_f) begin
            if (q.size() == 0) begin
                chk(1'b0, "R7 unexpected word", out_word, 67'h0);
            end else begin
                e = q.pop_front();
                chk(out_word[66:65] == e.w[66:65], "R1 R2 header", out_word, e.w);
                chk(out_word[64] == e.w[64], "R4 inversion flag", out_word, e.w);
                chk(out_word[63:0] == e.w[63:0], "R3 R9 payload", out_word, e.w);
                if (e.rdz) chk(out_word[64] == 1'b0, "R6 flag at zero RD", out_word, e.w);
                wd = (out_word[64] ? 1 : -1) + 2 * pop64(out_word[63:0]) - 64;
                obs_rd += wd;
                chk(iabs(obs_rd) <= 96, "R5 running disparity bound",
                    67'(iabs(obs_rd)), 67'd96);
            end
        end
        if (in_f) model_accept(in_hdr, in_payload);
        prev_stall   = out_valid && !out_ready;
        prev_word    = out_word;
        last_in_fire = in_f;
        exp_ov       = in_f ? 1'b1 : (out_f ? 1'b0 : exp_ov);
    endtask

    task automatic run_phase(input int n, input int mode, input int pv, input int pr);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (!in_valid || last_in_fire) begin
                in_valid   = ($urandom % 100) < pv;
                in_hdr     = ($urandom % 2) ? 2'b01 : 2'b10;
                in_payload = gen(mode);
            end
            out_ready = ($urandom % 100) < pr;
            settle_and_check();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_hist = '0; m_rd = 0; obs_rd = 0;
        exp_ov = 0; prev_stall = 0; prev_word = '0; last_in_fire = 0;
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        in_hdr = 2'b01; in_payload = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0, "R10 out_valid in reset", {66'b0, out_valid}, 67'h0);
        chk(in_ready == 1'b1, "R10 in_ready in reset", {66'b0, in_ready}, 67'h1);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid after reset", {66'b0, out_valid}, 67'h0);
        chk(in_ready == 1'b1, "R10 in_ready after reset", {66'b0, in_ready}, 67'h1);

        run_phase(2000, 0, 100, 100);   // streaming random data
        run_phase(2000, 0, 60, 40);     // R9: gaps and backpressure
        run_phase(500, 1, 90, 70);      // all-zero input
        run_phase(500, 2, 90, 70);      // all-one input
        run_phase(1500, 3, 80, 60);     // R5: extreme scrambled disparity
        run_phase(2500, 4, 85, 50);     // R5: skewed scrambled words
        run_phase(1500, 5, 85, 75);     // R6: balanced and near-empty words
        run_phase(1000, 0, 100, 10);    // R8: heavy stall

        // Drain: every accepted word leaves, then the stage is empty (R7).
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (k > 0) @(negedge clk);
            out_ready = 1'b1;
            settle_and_check();
        end
        chk(q.size() == 0, "R7 words left after drain", 67'(q.size()), 67'h0);
        chk(out_valid == 1'b0, "R7 stage empty after drain", {66'b0, out_valid}, 67'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule